// File: doc/BRIEF.md
# Processor Bus Memory Emulator with Cycle Trace

This block stands in for both the clock source and the whole memory of an 8-bit processor. It generates the processor clock from the system clock. In each processor cycle it samples the address and read/write lines during the low phase. On a read it drives a byte from its own 1 KiB store onto the data bus for the whole high phase. On a write it keeps the bus released and stores the byte it finds on the bus at the falling edge that ends the cycle.

For every completed cycle the block emits one trace record. The record carries a timestamp, the 10-bit address, the read/write flag and the data byte. Records leave on a valid/ready stream. When the consumer is slow, the block stretches the processor clock instead of dropping records.

Only address bits 9:0 are decoded, so four 256-byte pages repeat across the 64 KiB processor space:

- Page 0 is zero page.
- Page 1 is the stack.
- Page 2 holds code.
- Page 3 holds the reset vector at offsets 0x3FC/0x3FD and the interrupt vector at offsets 0x3FE/0x3FF.

A separate preload port writes the program image while the processor is held by the pause input.

Top module: `bus_mem_tracer`

## Requirements
- R1: While reset is held, `cpu_clk` is 1, `data_oe` is 0 and `trace_valid` is 0. For the first 1024 system clocks after reset, the block fills the store and keeps `cpu_clk` high. Preload writes made during those 1024 clocks are discarded. The first falling edge of `cpu_clk` waits until the fill is done and `pause` is low.
- R2: After the fill, every location reads 0xEA unless it has been written. A preload write (`pre_we`=1) stores `pre_data` at `pre_addr` on the next system clock edge.
- R3: Only `cpu_addr[9:0]` selects a location. For example, addresses 0xFFFC, 0x8201, 0x4033 and 0xC136 reach offsets 0x3FC, 0x201, 0x033 and 0x136.
- R4: Each low phase of `cpu_clk` lasts `half_period` system clocks, with a value of 0 treated as 1. Each high phase lasts the same, unless it is held by R9 or R10.
- R5: When `cpu_rw`=1 (read) at the end of the low phase, `data_oe` rises together with `cpu_clk`. `data_out` holds the stored byte for the whole high phase, and both drop at the falling edge.
- R6: When `cpu_rw`=0 (write), `data_oe` stays 0 for the whole cycle. The value of `data_in` at the falling edge is stored and is returned by later reads.
- R7: Each falling edge of `cpu_clk` presents a new trace record in the same clock. The record holds the address offset, the read/write flag, and the data byte: the byte driven for a read, or the byte captured for a write.
- R8: `trace_ts` is a free-running count of system clocks captured at the falling edge. The difference between two records equals the number of system clocks between their falling edges.
- R9: A record that is not accepted stays valid and unchanged. While it is pending, `cpu_clk` is held high, so no record is lost.
- R10: While `pause` is 1, `cpu_clk` is held high once it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_period | input | 8 | System clocks per processor clock phase (0 acts as 1) |
| pause | input | 1 | Hold the processor clock high |
| cpu_clk | output | 1 | Processor clock |
| cpu_addr | input | 16 | Processor address bus |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| data_in | input | 8 | Value present on the data bus |
| data_out | output | 8 | Value to drive on the data bus |
| data_oe | output | 1 | Data bus drive enable |
| pre_we | input | 1 | Preload write strobe |
| pre_addr | input | 10 | Preload offset |
| pre_data | input | 8 | Preload byte |
| trace_valid | output | 1 | Trace record available |
| trace_ready | input | 1 | Consumer accepts the record |
| trace_ts | output | 32 | Record timestamp |
| trace_addr | output | 10 | Record address offset |
| trace_rw | output | 1 | Record read/write flag |
| trace_data | output | 8 | Record data byte |

## Verification
The read byte and `data_oe` are registered at the rise, so the bench compares them in the half-clock after the system edge where `cpu_clk` turns high. The bench holds them and compares them again on every sample of the high phase. The trace record appears in the same edge as the fall, so the bench queues the expected record when it observes that fall. It pops and compares the record on the first sample where valid and ready are both high, because the handshake completes at the next edge. Phase lengths are measured in samples between observed edges. A high phase is only timed when neither pause nor a pending record could have stretched it.

// File: rtl/bmt_pkg.sv
package bmt_pkg;
    typedef enum logic [1:0] {
        PH_FILL = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;
endpackage

// File: rtl/bmt_phase_timer.sv
module bmt_phase_timer #(
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] half_period,
    input  logic             restart,
    output logic             expired
);
    logic [PER_W-1:0] cnt_d, cnt_q;
    logic [PER_W-1:0] lim;

    always_comb begin
        lim     = (half_period == '0) ? '0 : half_period - 1'b1;
        expired = (cnt_q >= lim);
        if (restart)      cnt_d = '0;
        else if (expired) cnt_d = cnt_q;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/bmt_tstamp.sv
module bmt_tstamp #(
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TS_W-1:0] now
);
    logic [TS_W-1:0] now_d, now_q;

    always_comb now_d = now_q + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) now_q <= '0;
        else        now_q <= now_d;
    end

    assign now = now_q;
endmodule

// File: rtl/bmt_mem.sv
module bmt_mem #(
    parameter int          AW        = 10,
    parameter int          DW        = 8,
    parameter logic [7:0]  FILL_BYTE = 8'hEA
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pre_we,
    input  logic [AW-1:0] pre_addr,
    input  logic [DW-1:0] pre_data,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          fill_done
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store_q [DEPTH];
    logic [AW:0]   fill_d, fill_q;
    logic          we;
    logic [AW-1:0] wa;
    logic [DW-1:0] wd;

    always_comb begin
        fill_done = fill_q[AW];
        fill_d    = fill_q;
        we        = 1'b0;
        wa        = '0;
        wd        = '0;
        if (!fill_done) begin
            we     = 1'b1;
            wa     = fill_q[AW-1:0];
            wd     = DW'(FILL_BYTE);
            fill_d = fill_q + 1'b1;
        end else if (pre_we) begin
            we = 1'b1;
            wa = pre_addr;
            wd = pre_data;
        end else if (bus_we) begin
            we = 1'b1;
            wa = bus_addr;
            wd = bus_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fill_q <= '0;
        else        fill_q <= fill_d;
    end

    always_ff @(posedge clk) begin
        if (we) store_q[wa] <= wd;
    end

    assign rd_data = store_q[rd_addr];
endmodule

// File: rtl/bus_mem_tracer.sv
module bus_mem_tracer #(
    parameter int         BUS_AW    = 16,
    parameter int         MEM_AW    = 10,
    parameter int         DW        = 8,
    parameter int         TS_W      = 32,
    parameter int         PER_W     = 8,
    parameter logic [7:0] FILL_BYTE = 8'hEA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PER_W-1:0]  half_period,
    input  logic              pause,
    output logic              cpu_clk,
    input  logic [BUS_AW-1:0] cpu_addr,
    input  logic              cpu_rw,
    input  logic [DW-1:0]     data_in,
    output logic [DW-1:0]     data_out,
    output logic              data_oe,
    input  logic              pre_we,
    input  logic [MEM_AW-1:0] pre_addr,
    input  logic [DW-1:0]     pre_data,
    output logic              trace_valid,
    input  logic              trace_ready,
    output logic [TS_W-1:0]   trace_ts,
    output logic [MEM_AW-1:0] trace_addr,
    output logic              trace_rw,
    output logic [DW-1:0]     trace_data
);
    import bmt_pkg::*;

    typedef struct packed {
        phase_e            phase;
        logic              clk_o;
        logic              oe;
        logic [DW-1:0]     dout;
        logic [MEM_AW-1:0] addr;
        logic              rw;
        logic              tvalid;
        logic [TS_W-1:0]   tts;
        logic [MEM_AW-1:0] taddr;
        logic              trw;
        logic [DW-1:0]     tdata;
    } ctl_t;

    ctl_t              ctl_d, ctl_q;
    logic              fill_done, expired, restart, bus_we;
    logic [DW-1:0]     rd_data;
    logic [TS_W-1:0]   ts_now;
    logic [MEM_AW-1:0] rd_addr;
    logic              unused_hi;

    assign unused_hi = ^cpu_addr[BUS_AW-1:MEM_AW];
    assign rd_addr   = cpu_addr[MEM_AW-1:0];

    bmt_mem #(.AW(MEM_AW), .DW(DW), .FILL_BYTE(FILL_BYTE)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data),
        .bus_we(bus_we), .bus_addr(ctl_q.addr), .bus_data(data_in),
        .rd_addr(rd_addr), .rd_data(rd_data), .fill_done(fill_done)
    );

    bmt_phase_timer #(.PER_W(PER_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .half_period(half_period),
        .restart(restart), .expired(expired)
    );

    bmt_tstamp #(.TS_W(TS_W)) u_ts (
        .clk(clk), .rst_n(rst_n), .now(ts_now)
    );

    always_comb begin
        ctl_d   = ctl_q;
        restart = 1'b0;
        bus_we  = 1'b0;
        if (ctl_q.tvalid && trace_ready) ctl_d.tvalid = 1'b0;
        unique case (ctl_q.phase)
            PH_FILL: begin
                if (fill_done && !pause) begin
                    ctl_d.phase = PH_LOW;
                    ctl_d.clk_o = 1'b0;
                    restart     = 1'b1;
                end
            end
            PH_LOW: begin
                if (expired) begin
                    ctl_d.addr  = cpu_addr[MEM_AW-1:0];
                    ctl_d.rw    = cpu_rw;
                    ctl_d.oe    = cpu_rw;
                    ctl_d.dout  = cpu_rw ? rd_data : '0;
                    ctl_d.phase = PH_HIGH;
                    ctl_d.clk_o = 1'b1;
                    restart     = 1'b1;
                end
            end
            PH_HIGH: begin
                if (expired && !pause && !(ctl_q.tvalid && !trace_ready)) begin
                    bus_we       = !ctl_q.rw;
                    ctl_d.tvalid = 1'b1;
                    ctl_d.tts    = ts_now;
                    ctl_d.taddr  = ctl_q.addr;
                    ctl_d.trw    = ctl_q.rw;
                    ctl_d.tdata  = ctl_q.rw ? ctl_q.dout : data_in;
                    ctl_d.oe     = 1'b0;
                    ctl_d.phase  = PH_LOW;
                    ctl_d.clk_o  = 1'b0;
                    restart      = 1'b1;
                end
            end
            default: ctl_d.phase = PH_FILL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.phase <= PH_FILL;
            ctl_q.clk_o <= 1'b1;
            ctl_q.rw    <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cpu_clk     = ctl_q.clk_o;
    assign data_oe     = ctl_q.oe;
    assign data_out    = ctl_q.dout;
    assign trace_valid = ctl_q.tvalid;
    assign trace_ts    = ctl_q.tts;
    assign trace_addr  = ctl_q.taddr;
    assign trace_rw    = ctl_q.trw;
    assign trace_data  = ctl_q.tdata;
endmodule

// File: rtl/bmt_chk.sv
module bmt_chk #(
    parameter int MEM_AW = 10,
    parameter int DW     = 8,
    parameter int TS_W   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pause,
    input logic              cpu_clk,
    input logic              cpu_rw,
    input logic              data_oe,
    input logic              trace_valid,
    input logic              trace_ready,
    input logic [TS_W-1:0]   trace_ts,
    input logic [MEM_AW-1:0] trace_addr,
    input logic              trace_rw,
    input logic [DW-1:0]     trace_data
);
    // R5
    oe_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_oe) |-> $past(cpu_rw));

    // R6
    oe_only_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> cpu_clk);

    // R7
    record_at_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trace_valid) |-> $fell(cpu_clk));

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk && trace_valid && !trace_ready) |=> cpu_clk);

    // R9
    record_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trace_valid && !trace_ready) |=> (trace_valid && $stable(trace_ts)
            && $stable(trace_addr) && $stable(trace_rw) && $stable(trace_data)));

    // R10
    pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk && pause) |=> cpu_clk);
endmodule

bind bus_mem_tracer bmt_chk #(.MEM_AW(MEM_AW), .DW(DW), .TS_W(TS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pause(pause), .cpu_clk(cpu_clk),
    .cpu_rw(cpu_rw), .data_oe(data_oe), .trace_valid(trace_valid),
    .trace_ready(trace_ready), .trace_ts(trace_ts), .trace_addr(trace_addr),
    .trace_rw(trace_rw), .trace_data(trace_data)
);

// File: tb/tb_bus_mem_tracer.sv
module tb_bus_mem_tracer;
    logic        clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic [7:0]  half_period = 8'd2;
    logic        pause = 1'b1;
    logic [15:0] cpu_addr = 16'h0000;
    logic        cpu_rw = 1'b1;
    logic [7:0]  data_in = 8'h00;
    logic        pre_we = 1'b0;
    logic [9:0]  pre_addr = '0;
    logic [7:0]  pre_data = '0;
    logic        trace_ready = 1'b1;
    logic        cpu_clk, data_oe, trace_valid, trace_rw;
    logic [7:0]  data_out, trace_data;
    logic [31:0] trace_ts;
    logic [9:0]  trace_addr;

    bus_mem_tracer dut (
        .clk(clk), .rst_n(rst_n), .half_period(half_period), .pause(pause),
        .cpu_clk(cpu_clk), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
        .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
        .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data),
        .trace_valid(trace_valid), .trace_ready(trace_ready),
        .trace_ts(trace_ts), .trace_addr(trace_addr), .trace_rw(trace_rw),
        .trace_data(trace_data)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic [15:0] a;
        logic        rw;
        logic [7:0]  wd;
    } op_t;

    function automatic op_t op_at(input int i);
        case (i)
            0:  op_at = {16'hFFFC, 1'b1, 8'h00};   // R3 reset vector low
            1:  op_at = {16'hFFFD, 1'b1, 8'h00};   // R3 reset vector high
            2:  op_at = {16'h0200, 1'b1, 8'h00};
            3:  op_at = {16'h8201, 1'b1, 8'h00};   // R3 mirror
            4:  op_at = {16'h0155, 1'b1, 8'h00};   // R2 untouched
            5:  op_at = {16'h0033, 1'b0, 8'h00};   // R6
            6:  op_at = {16'h0033, 1'b1, 8'h00};
            7:  op_at = {16'h4033, 1'b0, 8'h5C};   // R3 R6
            8:  op_at = {16'h0033, 1'b1, 8'h00};
            9:  op_at = {16'h0136, 1'b0, 8'h02};
            10: op_at = {16'hC136, 1'b1, 8'h00};
            11: op_at = {16'h0010, 1'b1, 8'h00};   // R1 fill-time preload lost
            12: op_at = {16'h1234, 1'b0, 8'hA5};
            13: op_at = {16'h0234, 1'b1, 8'h00};
            default: op_at = {16'hFC00 | 16'(i % 512), 1'b1, 8'h00};
        endcase
    endfunction

    logic [7:0] mm [1024];
    logic [9:0] qa[$];
    logic       qrw[$];
    logic [7:0] qd[$];
    int         qc[$];

    bit   mon_en = 1'b0;
    int   cyc = 0;
    bit   prev_clk = 1'b1;
    bit   started = 1'b0;
    int   fall_cyc = 0;
    int   rise_cyc = 0;
    bit   held = 1'b0;
    op_t  cur = '0;
    logic [7:0] exp_rd = 8'h00;
    int   op_idx = 0;
    int   falls = 0;
    int   recs = 0;
    bit   have_base = 1'b0;
    int   base_ts = 0;
    int   base_cyc = 0;
    int   hp_eff;

    always @(negedge clk) begin
        if (mon_en) begin
            cyc++;
            hp_eff = (half_period == 0) ? 1 : int'(half_period);
            if (prev_clk && !cpu_clk) begin
                if (started) begin
                    if (!held) chk((cyc - rise_cyc) == hp_eff, "R4 high phase", cyc - rise_cyc, hp_eff);
                    if (!cur.rw) mm[cur.a[9:0]] = cur.wd;
                    qa.push_back(cur.a[9:0]);
                    qrw.push_back(cur.rw);
                    qd.push_back(cur.rw ? exp_rd : cur.wd);
                    qc.push_back(cyc);
                    falls++;
                    chk(trace_valid === 1'b1, "R7 record at fall", trace_valid, 1);
                end
                started  = 1'b1;
                fall_cyc = cyc;
                cur      = op_at(op_idx);
                op_idx++;
                cpu_addr = cur.a;
                cpu_rw   = cur.rw;
                data_in  = cur.rw ? 8'h3C : cur.wd;
            end else if (!prev_clk && cpu_clk) begin
                chk((cyc - fall_cyc) == hp_eff, "R4 low phase", cyc - fall_cyc, hp_eff);
                rise_cyc = cyc;
                held     = 1'b0;
                exp_rd   = mm[cur.a[9:0]];
                chk(data_oe === cur.rw, "R5/R6 drive at rise", data_oe, cur.rw);
                if (cur.rw) chk(data_out === exp_rd, "R5 read byte", data_out, exp_rd);
            end else if (started && cpu_clk) begin
                chk(data_oe === cur.rw, "R5/R6 drive in high", data_oe, cur.rw);
                if (cur.rw) chk(data_out === exp_rd, "R5 byte held", data_out, exp_rd);
            end else if (started && !cpu_clk) begin
                chk(data_oe === 1'b0, "R6 no drive in low", data_oe, 0);
            end
            if (cpu_clk && (pause || (trace_valid && !trace_ready))) held = 1'b1;
            if (trace_valid && trace_ready) begin
                if (qa.size() == 0) begin
                    chk(1'b0, "R7 unexpected record", trace_addr, 0);
                end else begin
                    chk(trace_addr === qa[0], "R7 addr", trace_addr, qa[0]);
                    chk(trace_rw === qrw[0], "R7 rw", trace_rw, qrw[0]);
                    chk(trace_data === qd[0], "R7 data", trace_data, qd[0]);
                    if (!have_base) begin
                        have_base = 1'b1;
                        base_ts   = int'(trace_ts);
                        base_cyc  = qc[0];
                    end else begin
                        chk((int'(trace_ts) - base_ts) == (qc[0] - base_cyc), "R8 timestamp",
                            int'(trace_ts) - base_ts, qc[0] - base_cyc);
                    end
                    void'(qa.pop_front());
                    void'(qrw.pop_front());
                    void'(qd.pop_front());
                    void'(qc.pop_front());
                    recs++;
                end
            end
            prev_clk = cpu_clk;
        end
    end

    task automatic preload(input logic [9:0] a, input logic [7:0] d, input bit track);
        @(posedge clk); #1;
        pre_we = 1'b1; pre_addr = a; pre_data = d;
        @(posedge clk); #1;
        pre_we = 1'b0;
        if (track) mm[a] = d;
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        int f0;
        for (int k = 0; k < 1024; k++) mm[k] = 8'hEA;
        step(5);
        @(negedge clk);
        chk(cpu_clk === 1'b1, "R1 clock high in reset", cpu_clk, 1);
        chk(data_oe === 1'b0, "R1 no drive in reset", data_oe, 0);
        chk(trace_valid === 1'b0, "R1 no record in reset", trace_valid, 0);
        @(posedge clk); #1;
        rst_n  = 1'b1;
        mon_en = 1'b1;
        preload(10'h010, 8'h77, 1'b0);   // R1: lands in fill window, discarded
        step(1100);
        chk(!started && cpu_clk === 1'b1, "R1 R10 clock held after fill", cpu_clk, 1);
        preload(10'h200, 8'h11, 1'b1);   // R2
        preload(10'h201, 8'h22, 1'b1);
        preload(10'h3FC, 8'h00, 1'b1);
        preload(10'h3FD, 8'h02, 1'b1);
        pause = 1'b0;
        step(80);
        chk(op_idx > 14, "R4 cycles ran", op_idx, 15);
        // R9 stall
        trace_ready = 1'b0;
        step(10);
        f0 = falls;
        step(40);
        chk(falls == f0, "R9 no fall while pending", falls, f0);
        chk(cpu_clk === 1'b1 && trace_valid === 1'b1, "R9 held high with record", cpu_clk, 1);
        trace_ready = 1'b1;
        step(40);
        // R10 pause
        pause = 1'b1;
        step(10);
        f0 = falls;
        step(30);
        chk(falls == f0 && cpu_clk === 1'b1, "R10 paused", falls, f0);
        half_period = 8'd0;              // R4 zero acts as one
        pause = 1'b0;
        step(40);
        pause = 1'b1;
        step(10);
        half_period = 8'd5;
        pause = 1'b0;
        step(100);
        pause = 1'b1;
        step(30);
        chk(qa.size() == 0, "R9 all records delivered", qa.size(), 0);
        chk(recs == falls, "R9 record count", recs, falls);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule